// File: doc/BRIEF.md
# Cartridge 32 KB Program Bank Mapper

This block is the bank-switching logic of a simple game cartridge that sits on an 8-bit CPU bus. The CPU stores a byte anywhere in the upper half of its address space. That byte becomes the bank number, and the bank number picks which 32 KB page of a larger program ROM fills the whole `$8000-$FFFF` window. No part of the window is fixed. While the CPU writes, the ROM is also driving the data bus. The block models this conflict: it takes the ROM's read data as an input and latches the bitwise AND of the two bytes.

On the video side, the block passes a fixed 8 KB character-RAM address and enable straight through. It also produces the nametable address line that sets mirroring:
- With `SINGLE_SCREEN=0`, a strap input chooses horizontal or vertical mirroring.
- With `SINGLE_SCREEN=1`, bit 4 of the latched byte selects the lower or the upper nametable.

Every output is registered. Each output therefore reflects the inputs sampled at the previous clock edge.

The CPU bus signals are sampled on a fast system clock `clk`. A write is taken at the end of the CPU cycle, on the first `clk` edge that sees the enable phase `cpu_m2` low after it was high. Reset clears the latch to 0 so that simulation is deterministic. Software must still write a bank before relying on it, and every page must carry its own vectors.

Top module: `cart_bank32_mapper`

## Requirements
- R1: While `rst` is high at a clock edge, every output becomes 0 and the bank latch becomes 0.
- R2: A write loads the latch. A write is a `clk` edge where `cpu_m2` is low, `cpu_m2` was high at the previous edge, and the last values sampled while `cpu_m2` was high had `cpu_rw`=0 and `cpu_addr[15]`=1. The value loaded is `cpu_wdata & rom_rdata` from the last edge where `cpu_m2` was high. The new bank appears on `prg_addr` one edge later.
- R3: A write cycle with `cpu_addr[15]`=0 leaves the latch unchanged.
- R4: A cycle with `cpu_rw`=1 never changes the latch, and the latch holds on every edge that is not a write.
- R5: `prg_addr[14:0]` equals `cpu_addr[14:0]` sampled at the previous edge.
- R6: `prg_ce` is 1 exactly when the previous edge sampled `cpu_addr[15]`=1 and `cpu_rw`=1.
- R7: `prg_addr[15+BANK_BITS-1:15]` equals the low `BANK_BITS` bits of the latch as it stood at the previous edge. Higher latch bits do not affect the page.
- R8: `chr_addr` equals `ppu_addr[12:0]` sampled at the previous edge. `chr_ce` is the inverse of the sampled `ppu_addr[13]`.
- R9: With `SINGLE_SCREEN=0`, `nt_a10` follows `ppu_addr[10]` when `mirror_strap`=1 (vertical mirroring) and `ppu_addr[11]` when `mirror_strap`=0 (horizontal mirroring), in both cases one edge later.
- R10: With `SINGLE_SCREEN=1`, `nt_a10` equals latch bit 4 as it stood at the previous edge, and `mirror_strap` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the CPU and video buses |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | Data the CPU drives during a write |
| cpu_rw | input | 1 | CPU read (1) or write (0) |
| cpu_m2 | input | 1 | CPU enable phase; a write ends on its falling edge |
| rom_rdata | input | 8 | Byte the program ROM drives at the current address |
| ppu_addr | input | 14 | Video address bus |
| mirror_strap | input | 1 | Board strap: 1 vertical, 0 horizontal mirroring |
| prg_addr | output | 15+BANK_BITS | Program ROM address |
| prg_ce | output | 1 | Program ROM enable, active high |
| chr_addr | output | 13 | Character RAM address |
| chr_ce | output | 1 | Character RAM enable, active high |
| nt_a10 | output | 1 | Nametable RAM address line 10 |

## Verification
The bench runs two instances side by side:
- a 4-bit-bank instance with strap-controlled mirroring;
- a 2-bit-bank instance with single-screen mirroring.

Directed writes separate the conflict AND from a plain copy, because the ROM bytes clear bits that the CPU drives high. Writes below `$8000` and read cycles with an enable pulse show whether the address and direction qualifiers are decoded. A value with its upper nibble set shows the truncation to the bank width and the single-screen bit. Free-running random bus traffic, with arbitrary enable toggling, is checked against a behavioural model on every clock. This catches commits taken on the wrong edge or with stale captured values.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CPU_AW = 16;
  localparam int CPU_DW = 8;
  localparam int PPU_AW = 14;
  localparam int WIN_AW = 15;   // 32 KB window offset bits
  localparam int CHR_AW = 13;   // 8 KB character RAM

  typedef enum logic {
    MIR_HORZ = 1'b0,
    MIR_VERT = 1'b1
  } mirror_e;

  // Mirroring line chosen by the board strap
  function automatic logic strap_nt_line(mirror_e mode, logic [PPU_AW-1:0] pa);
    return (mode == MIR_VERT) ? pa[10] : pa[11];
  endfunction
endpackage

// File: rtl/cbm_cpu_capture.sv
module cbm_cpu_capture
  import cbm_pkg::*;
#(
  parameter bit BUS_CONFLICT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [CPU_DW-1:0] cpu_wdata,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  input  logic [CPU_DW-1:0] rom_rdata,
  output logic              m2_seen,
  output logic              wr_stb,
  output logic [CPU_DW-1:0] wr_val
);
  logic              hold_a15;
  logic              hold_rw;
  logic [CPU_DW-1:0] hold_val;
  logic [CPU_DW-1:0] bus_val;

  generate
    if (BUS_CONFLICT) begin : g_conflict
      assign bus_val = cpu_wdata & rom_rdata;
    end else begin : g_clean
      logic unused_rom;
      assign unused_rom = ^rom_rdata;
      assign bus_val = cpu_wdata;
    end
  endgenerate

  // Capture bus state while the enable phase is high
  always_ff @(posedge clk) begin
    if (rst) begin
      m2_seen  <= 1'b0;
      hold_a15 <= 1'b0;
      hold_rw  <= 1'b1;
      hold_val <= '0;
    end else begin
      m2_seen <= cpu_m2;
      if (cpu_m2) begin
        hold_a15 <= cpu_addr[CPU_AW-1];
        hold_rw  <= cpu_rw;
        hold_val <= bus_val;
      end
    end
  end

  logic unused_addr;
  assign unused_addr = ^cpu_addr[CPU_AW-2:0];

  // Commit on the end of a write cycle in the upper half
  assign wr_stb = m2_seen & ~cpu_m2 & ~hold_rw & hold_a15;
  assign wr_val = hold_val;
endmodule

// File: rtl/cbm_bank_reg.sv
module cbm_bank_reg
  import cbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [CPU_DW-1:0] wr_val,
  output logic [CPU_DW-1:0] lat_q
);
  always_ff @(posedge clk) begin
    if (rst)         lat_q <= '0;
    else if (wr_stb) lat_q <= wr_val;
  end
endmodule

// File: rtl/cbm_map_out.sv
module cbm_map_out
  import cbm_pkg::*;
#(
  parameter int BANK_BITS     = 2,
  parameter bit SINGLE_SCREEN = 1'b0,
  localparam int PRG_AW       = WIN_AW + BANK_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_DW-1:0] lat_q,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic              mirror_strap,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              prg_ce,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              chr_ce,
  output logic              nt_a10
);
  logic nt_next;
  logic unused_lat;
  assign unused_lat = ^lat_q;

  generate
    if (SINGLE_SCREEN) begin : g_single
      logic unused_strap;
      assign unused_strap = mirror_strap;
      assign nt_next = lat_q[4];
    end else begin : g_strap
      assign nt_next = strap_nt_line(mirror_e'(mirror_strap), ppu_addr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_addr <= '0;
      prg_ce   <= 1'b0;
      chr_addr <= '0;
      chr_ce   <= 1'b0;
      nt_a10   <= 1'b0;
    end else begin
      prg_addr <= {lat_q[BANK_BITS-1:0], cpu_addr[WIN_AW-1:0]};
      prg_ce   <= cpu_addr[CPU_AW-1] & cpu_rw;
      chr_addr <= ppu_addr[CHR_AW-1:0];
      chr_ce   <= ~ppu_addr[CHR_AW];
      nt_a10   <= nt_next;
    end
  end
endmodule

// File: rtl/cart_bank32_mapper.sv
module cart_bank32_mapper
  import cbm_pkg::*;
#(
  parameter int BANK_BITS     = 2,
  parameter bit SINGLE_SCREEN = 1'b0,
  parameter bit BUS_CONFLICT  = 1'b1,
  localparam int PRG_AW       = WIN_AW + BANK_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  input  logic [7:0]        rom_rdata,
  input  logic [13:0]       ppu_addr,
  input  logic              mirror_strap,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              prg_ce,
  output logic [12:0]       chr_addr,
  output logic              chr_ce,
  output logic              nt_a10
);
  logic              m2_seen;
  logic              wr_stb;
  logic [CPU_DW-1:0] wr_val;
  logic [CPU_DW-1:0] lat_q;

  cbm_cpu_capture #(.BUS_CONFLICT(BUS_CONFLICT)) u_cap (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .rom_rdata(rom_rdata),
    .m2_seen(m2_seen), .wr_stb(wr_stb), .wr_val(wr_val)
  );

  cbm_bank_reg u_bank (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_val(wr_val), .lat_q(lat_q)
  );

  cbm_map_out #(.BANK_BITS(BANK_BITS), .SINGLE_SCREEN(SINGLE_SCREEN)) u_map (
    .clk(clk), .rst(rst), .lat_q(lat_q), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .ppu_addr(ppu_addr), .mirror_strap(mirror_strap), .prg_addr(prg_addr),
    .prg_ce(prg_ce), .chr_addr(chr_addr), .chr_ce(chr_ce), .nt_a10(nt_a10)
  );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int BANK_BITS     = 2,
  parameter bit SINGLE_SCREEN = 1'b0,
  localparam int PRG_AW       = 15 + BANK_BITS
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic              cpu_rw,
  input logic              cpu_m2,
  input logic [13:0]       ppu_addr,
  input logic              mirror_strap,
  input logic              m2_seen,
  input logic [7:0]        lat_q,
  input logic [PRG_AW-1:0] prg_addr,
  input logic              prg_ce,
  input logic [12:0]       chr_addr,
  input logic              chr_ce,
  input logic              nt_a10
);
  p_offset_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prg_addr[14:0] == $past(cpu_addr[14:0]));

  p_rom_enable_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prg_ce == $past(cpu_addr[15] && cpu_rw));

  p_page_from_latch_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prg_addr[PRG_AW-1:15] == $past(lat_q[BANK_BITS-1:0]));

  p_latch_holds_r4: assert property (@(posedge clk) disable iff (rst)
    !(m2_seen && !cpu_m2) |=> $stable(lat_q));

  p_chr_pass_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (chr_addr == $past(ppu_addr[12:0])) && (chr_ce == !$past(ppu_addr[13])));

  generate
    if (SINGLE_SCREEN) begin : g_ss
      logic unused_strap;
      assign unused_strap = mirror_strap;
      p_single_screen_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> nt_a10 == $past(lat_q[4]));
    end else begin : g_fixed
      p_strap_mirror_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> nt_a10 == $past(mirror_strap ? ppu_addr[10] : ppu_addr[11]));
    end
  endgenerate
endmodule

bind cart_bank32_mapper cbm_checker #(.BANK_BITS(BANK_BITS), .SINGLE_SCREEN(SINGLE_SCREEN)) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .cpu_m2(cpu_m2),
  .ppu_addr(ppu_addr), .mirror_strap(mirror_strap), .m2_seen(m2_seen),
  .lat_q(lat_q), .prg_addr(prg_addr), .prg_ce(prg_ce), .chr_addr(chr_addr),
  .chr_ce(chr_ce), .nt_a10(nt_a10)
);

// File: tb/cart_bank32_mapper_bench.sv
module cart_bank32_mapper_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  rom_rdata = 8'hFF;
  logic        cpu_rw = 1'b1;
  logic        cpu_m2 = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        mirror_strap = 1'b1;

  logic [18:0] prg_a;  logic ce_a;  logic [12:0] chr_a;  logic chrce_a;  logic nt_a;
  logic [16:0] prg_b;  logic ce_b;  logic [12:0] chr_b;  logic chrce_b;  logic nt_b;

  cart_bank32_mapper #(.BANK_BITS(4), .SINGLE_SCREEN(1'b0)) u_cart_bank32_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rw(cpu_rw),
    .cpu_m2(cpu_m2), .rom_rdata(rom_rdata), .ppu_addr(ppu_addr), .mirror_strap(mirror_strap),
    .prg_addr(prg_a), .prg_ce(ce_a), .chr_addr(chr_a), .chr_ce(chrce_a), .nt_a10(nt_a)
  );

  cart_bank32_mapper #(.BANK_BITS(2), .SINGLE_SCREEN(1'b1)) u_cart_bank32_mapper_ss (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rw(cpu_rw),
    .cpu_m2(cpu_m2), .rom_rdata(rom_rdata), .ppu_addr(ppu_addr), .mirror_strap(mirror_strap),
    .prg_addr(prg_b), .prg_ce(ce_b), .chr_addr(chr_b), .chr_ce(chrce_b), .nt_a10(nt_b)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  logic [7:0]  m_lat, m_val;
  logic        m_m2, m_a15, m_rw;
  logic [18:0] e_prg_a;
  logic [16:0] e_prg_b;
  logic        e_ce, e_chrce, e_nt_a, e_nt_b;
  logic [12:0] e_chr;

  always @(posedge clk) begin
    if (rst) begin
      m_lat = 0; m_val = 0; m_m2 = 0; m_a15 = 0; m_rw = 1;
      e_prg_a = 0; e_prg_b = 0; e_ce = 0; e_chrce = 0; e_nt_a = 0; e_nt_b = 0; e_chr = 0;
    end else begin
      e_prg_a = {m_lat[3:0], cpu_addr[14:0]};
      e_prg_b = {m_lat[1:0], cpu_addr[14:0]};
      e_ce    = cpu_addr[15] & cpu_rw;
      e_chr   = ppu_addr[12:0];
      e_chrce = !ppu_addr[13];
      e_nt_a  = mirror_strap ? ppu_addr[10] : ppu_addr[11];
      e_nt_b  = m_lat[4];
      if (m_m2 && !cpu_m2 && !m_rw && m_a15) m_lat = m_val;
      if (cpu_m2) begin
        m_a15 = cpu_addr[15];
        m_rw  = cpu_rw;
        m_val = cpu_wdata & rom_rdata;
      end
      m_m2 = cpu_m2;
    end
  end

  // Compare both instances against the model on every clock
  always @(posedge clk) begin
    #2;
    if (!done) begin
      cmp("R2/R7 page A", 32'(prg_a[18:15]), 32'(e_prg_a[18:15]));
      cmp("R2/R7 page B", 32'(prg_b[16:15]), 32'(e_prg_b[16:15]));
      cmp("R5 offset", 32'(prg_a[14:0]), 32'(e_prg_a[14:0]));
      cmp("R6 rom enable", 32'({ce_a, ce_b}), 32'({e_ce, e_ce}));
      cmp("R8 chr addr", 32'({chr_a, chr_b}), 32'({e_chr, e_chr}));
      cmp("R8 chr enable", 32'({chrce_a, chrce_b}), 32'({e_chrce, e_chrce}));
      cmp("R9 strap mirroring", 32'(nt_a), 32'(e_nt_a));
      cmp("R10 single screen", 32'(nt_b), 32'(e_nt_b));
    end
  end

  task automatic bus_cycle(logic [15:0] a, logic [7:0] d, logic [7:0] rom, logic rw);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; rom_rdata = rom; cpu_rw = rw; cpu_m2 = 1'b0;
    @(negedge clk); cpu_m2 = 1'b1;
    @(negedge clk);
    @(negedge clk); cpu_m2 = 1'b0;
    @(negedge clk);
  endtask

  task automatic probe(logic [15:0] a);
    cpu_addr = a; cpu_rw = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1 reset page A", 32'(prg_a), 32'h0);
    cmp("R1 reset page B", 32'(prg_b), 32'h0);
    cmp("R1 reset nt B", 32'(nt_b), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 latch zero after reset", 32'(prg_a[18:15]), 32'h0);

    // R2: plain write, ROM drives all ones
    bus_cycle(16'h8000, 8'h05, 8'hFF, 1'b0);
    probe(16'h8123);
    cmp("R2 write page A", 32'(prg_a), 32'h28123);
    cmp("R2 write page B", 32'(prg_b[16:15]), 32'h1);

    // R2: conflict, 0x0E AND 0x0B = 0x0A
    bus_cycle(16'hFFF0, 8'h0E, 8'h0B, 1'b0);
    probe(16'h8000);
    cmp("R2 conflict AND page A", 32'(prg_a[18:15]), 32'hA);

    // R3: write below $8000 ignored
    bus_cycle(16'h7FFF, 8'h03, 8'hFF, 1'b0);
    probe(16'h8000);
    cmp("R3 low write ignored", 32'(prg_a[18:15]), 32'hA);

    // R4: read cycle with enable pulse ignored
    bus_cycle(16'h9000, 8'h07, 8'h07, 1'b1);
    probe(16'h8000);
    cmp("R4 read ignored", 32'(prg_a[18:15]), 32'hA);

    // R7 and R10: upper bits set
    bus_cycle(16'hC000, 8'hF7, 8'hFF, 1'b0);
    probe(16'h8000);
    cmp("R7 truncated page A", 32'(prg_a[18:15]), 32'h7);
    cmp("R7 truncated page B", 32'(prg_b[16:15]), 32'h3);
    cmp("R10 bit4 high", 32'(nt_b), 32'h1);
    mirror_strap = 1'b0; ppu_addr = 14'h0000;
    @(negedge clk);
    cmp("R10 strap has no effect", 32'(nt_b), 32'h1);
    bus_cycle(16'hA000, 8'hEF, 8'hFF, 1'b0);
    probe(16'h8000);
    cmp("R10 bit4 low", 32'(nt_b), 32'h0);

    // R9: strap mirroring
    mirror_strap = 1'b1; ppu_addr = 14'h0400; @(negedge clk);
    cmp("R9 vertical A10", 32'(nt_a), 32'h1);
    ppu_addr = 14'h0800; @(negedge clk);
    cmp("R9 vertical ignores A11", 32'(nt_a), 32'h0);
    mirror_strap = 1'b0; @(negedge clk);
    cmp("R9 horizontal A11", 32'(nt_a), 32'h1);
    ppu_addr = 14'h0400; @(negedge clk);
    cmp("R9 horizontal ignores A10", 32'(nt_a), 32'h0);

    // R6 and R8
    probe(16'h8000);
    cmp("R6 enable on read high", 32'(ce_a), 32'h1);
    cpu_rw = 1'b0; @(negedge clk);
    cmp("R6 no enable on write", 32'(ce_a), 32'h0);
    probe(16'h7000);
    cmp("R6 no enable below window", 32'(ce_a), 32'h0);
    ppu_addr = 14'h2ABC; @(negedge clk);
    cmp("R8 chr addr", 32'(chr_a), 32'h0ABC);
    cmp("R8 chr disabled", 32'(chrce_a), 32'h0);
    ppu_addr = 14'h1555; @(negedge clk);
    cmp("R8 chr enabled", 32'(chrce_a), 32'h1);

    // Random bus traffic checked by the model each clock
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      cpu_addr     = 16'($urandom);
      cpu_wdata    = 8'($urandom);
      rom_rdata    = 8'($urandom);
      cpu_rw       = 1'($urandom);
      cpu_m2       = 1'($urandom);
      ppu_addr     = 14'($urandom);
      mirror_strap = 1'($urandom);
    end
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule